// File: doc/BRIEF.md
# Host-to-Controller Command Mailbox

This block is a small register file that carries commands from a host processor to an embedded power-management controller and carries the answers back. The host writes its registers through a 32-bit port. It can load a source pointer, a destination pointer and a 16-byte write buffer. It then writes the command word. That write marks the mailbox busy and presents one request to the controller side. The request carries the command, both pointers and the payload, with the unused payload bytes forced to zero.

The controller answers with a one-cycle completion strobe. The strobe carries an error flag, an 8-bit error code and four 32-bit result words. The host sees completion in one of two ways. It can poll the busy bit in the status register. It can also ask for an interrupt by setting a flag in the command word. That interrupt is a level output, and the host acknowledges it by writing one to the pending bit. Host timeouts belong to host software and are not part of this block.

The request side uses a valid/ready handshake. Once `req_valid` rises, it stays high, and every request field stays stable, until a cycle in which `req_ready` is high; the request is taken in that cycle. The completion side has no back-pressure. The block accepts a `done_valid` strobe only while busy and only after the request has been taken. At any other time the strobe is ignored.

Top module: `host_mailbox`

## Requirements
- R1: After reset, busy, error, error code and interrupt-pending are all 0. `irq` and `req_valid` are low, and every register reads as zero.
- R2: A write to offset 0x00 while not busy does three things on the next clock edge: it sets busy (status bit 0), stores the word, and raises `req_valid` with `req_cmd` equal to the written word. `req_valid`, `req_cmd`, `req_src`, `req_dst` and `req_data` then hold until a cycle with `req_ready` high, after which `req_valid` is low.
- R3: Command word layout: opcode in bits 7:0, interrupt request in bit 8, sub-opcode in bits 15:12, byte length in bits 23:16. Request payload byte i sits at `req_data[8i+7:8i]`, and word k at offset 0x80+4k is bytes 4k..4k+3 with the lowest byte at bits 7:0. A byte i is passed through only when i < length, so a length of 16 or more passes all 16 bytes; every other byte is zero.
- R4: While busy, writes to the command register, to the pointers (0x08, 0x0C) or to the write buffer have no effect. Such a write raises no second request and leaves the readback unchanged.
- R5: A `done_valid` strobe accepted while busy with the request already taken has these effects: it clears busy, loads result word k into offset 0x90+4k, copies the error flag into status bit 1, and sets status bits 23:16 to the error code, or to 0 when the error flag is low. A strobe that arrives while idle, or while the request is still pending, changes nothing.
- R6: An accepted completion sets interrupt-pending (status bit 2) only if command bit 8 was set. `irq` is high exactly while pending is set.
- R7: A status write with bit 2 set clears pending, and a status write with bit 2 clear leaves it alone. If an acknowledge and a completion that requests an interrupt arrive in the same cycle, pending ends up set.
- R8: Offsets 0x00, 0x08, 0x0C and 0x80–0x8C read back the last written values. Offsets 0x90–0x9C read the result words. Every other offset reads zero, and writes to 0x90–0x9C have no effect.
- R9: Accepting a new command clears the error bit and the error code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Host register write strobe |
| reg_addr | input | 8 | Host byte offset for read and write |
| reg_wdata | input | 32 | Host write data |
| reg_rdata | output | 32 | Host read data for `reg_addr` (combinational) |
| req_valid | output | 1 | Request to controller is valid |
| req_ready | input | 1 | Controller takes the request |
| req_cmd | output | 32 | Stored command word |
| req_src | output | 32 | Source pointer |
| req_dst | output | 32 | Destination pointer |
| req_data | output | 128 | Length-masked input payload |
| done_valid | input | 1 | Completion strobe from controller |
| done_err | input | 1 | Completion error flag |
| done_code | input | 8 | Completion error code |
| done_data | input | 128 | Four result words, word k at bits 32k+31:32k |
| irq | output | 1 | Level completion interrupt |

## Verification
A wrong internal state becomes visible at the ports within one clock. If busy is stuck, the host will either see a second request or see no request at all. If the pending flag is stuck, `irq` holds the wrong level. A badly latched command shows up as `req_cmd` and as payload bytes that break the length masking. Corrupted result or error state shows up in the status read and in the read-buffer read taken just after the completion strobe.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam int MAP_AW = 8;
  localparam int REG_W  = 32;

  localparam logic [MAP_AW-1:0] OFF_CMD  = 8'h00;
  localparam logic [MAP_AW-1:0] OFF_STS  = 8'h04;
  localparam logic [MAP_AW-1:0] OFF_SRC  = 8'h08;
  localparam logic [MAP_AW-1:0] OFF_DST  = 8'h0C;
  localparam logic [MAP_AW-1:0] OFF_WBUF = 8'h80;
  localparam logic [MAP_AW-1:0] OFF_RBUF = 8'h90;

  localparam int STS_BUSY = 0;
  localparam int STS_ERR  = 1;
  localparam int STS_PEND = 2;
  localparam int STS_CODE_LSB = 16;

  localparam int CMD_IRQ_BIT = 8;
  localparam int CMD_LEN_LSB = 16;
  localparam int CMD_LEN_W   = 8;
  localparam int CODE_W      = 8;
endpackage

// File: rtl/mbx_hostregs.sv
module mbx_hostregs
  import mbx_pkg::*;
#(
  parameter int WORDS = 4,
  localparam int BUF_W = WORDS * REG_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [MAP_AW-1:0] addr,
  input  logic [REG_W-1:0]  wdata,
  output logic [REG_W-1:0]  src_ptr,
  output logic [REG_W-1:0]  dst_ptr,
  output logic [BUF_W-1:0]  wbuf
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      src_ptr <= '0;
      dst_ptr <= '0;
    end else if (wr_en) begin
      if (addr == OFF_SRC) src_ptr <= wdata;
      if (addr == OFF_DST) dst_ptr <= wdata;
    end
  end

  for (genvar k = 0; k < WORDS; k++) begin : g_word
    localparam logic [MAP_AW-1:0] WADDR = OFF_WBUF + MAP_AW'(4 * k);
    always_ff @(posedge clk) begin
      if (!rst_n) wbuf[k*REG_W +: REG_W] <= '0;
      else if (wr_en && addr == WADDR) wbuf[k*REG_W +: REG_W] <= wdata;
    end
  end
endmodule

// File: rtl/mbx_core.sv
module mbx_core
  import mbx_pkg::*;
#(
  parameter int WORDS = 4,
  localparam int BUF_W = WORDS * REG_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_wr,
  input  logic              sts_wr,
  input  logic [REG_W-1:0]  wdata,
  input  logic              req_ready,
  input  logic              done_valid,
  input  logic              done_err,
  input  logic [CODE_W-1:0] done_code,
  input  logic [BUF_W-1:0]  done_data,
  output logic [REG_W-1:0]  cmd_q,
  output logic              busy,
  output logic              err,
  output logic [CODE_W-1:0] code,
  output logic              pend,
  output logic              req_valid,
  output logic [BUF_W-1:0]  rbuf
);
  logic cmd_take;
  logic done_take;

  assign cmd_take  = cmd_wr && !busy;
  assign done_take = done_valid && busy && !req_valid;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_q     <= '0;
      busy      <= 1'b0;
      err       <= 1'b0;
      code      <= '0;
      req_valid <= 1'b0;
      rbuf      <= '0;
    end else if (cmd_take) begin
      cmd_q     <= wdata;
      busy      <= 1'b1;
      req_valid <= 1'b1;
      err       <= 1'b0;
      code      <= '0;
    end else begin
      if (req_valid && req_ready) req_valid <= 1'b0;
      if (done_take) begin
        busy <= 1'b0;
        err  <= done_err;
        code <= done_err ? done_code : '0;
        rbuf <= done_data;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) pend <= 1'b0;
    else if (done_take && cmd_q[CMD_IRQ_BIT]) pend <= 1'b1;
    else if (sts_wr && wdata[STS_PEND]) pend <= 1'b0;
  end
endmodule

// File: rtl/mbx_payload_mask.sv
module mbx_payload_mask
  import mbx_pkg::*;
#(
  parameter int WORDS = 4,
  localparam int BYTES = WORDS * 4,
  localparam int BUF_W = WORDS * REG_W
) (
  input  logic [BUF_W-1:0]     wbuf,
  input  logic [CMD_LEN_W-1:0] len,
  output logic [BUF_W-1:0]     data
);
  for (genvar b = 0; b < BYTES; b++) begin : g_byte
    assign data[8*b +: 8] = (len > CMD_LEN_W'(b)) ? wbuf[8*b +: 8] : 8'h00;
  end
endmodule

// File: rtl/mbx_rdmux.sv
module mbx_rdmux
  import mbx_pkg::*;
#(
  parameter int WORDS = 4,
  localparam int BUF_W = WORDS * REG_W
) (
  input  logic [MAP_AW-1:0] addr,
  input  logic [REG_W-1:0]  cmd_q,
  input  logic              busy,
  input  logic              err,
  input  logic [CODE_W-1:0] code,
  input  logic              pend,
  input  logic [REG_W-1:0]  src_ptr,
  input  logic [REG_W-1:0]  dst_ptr,
  input  logic [BUF_W-1:0]  wbuf,
  input  logic [BUF_W-1:0]  rbuf,
  output logic [REG_W-1:0]  rdata
);
  logic [REG_W-1:0] sts_word;

  always_comb begin
    sts_word = '0;
    sts_word[STS_BUSY] = busy;
    sts_word[STS_ERR]  = err;
    sts_word[STS_PEND] = pend;
    sts_word[STS_CODE_LSB +: CODE_W] = code;
  end

  always_comb begin
    rdata = '0;
    if (addr == OFF_CMD) rdata = cmd_q;
    if (addr == OFF_STS) rdata = sts_word;
    if (addr == OFF_SRC) rdata = src_ptr;
    if (addr == OFF_DST) rdata = dst_ptr;
    for (int k = 0; k < WORDS; k++) begin
      if (addr == OFF_WBUF + MAP_AW'(4 * k)) rdata = wbuf[k*REG_W +: REG_W];
      if (addr == OFF_RBUF + MAP_AW'(4 * k)) rdata = rbuf[k*REG_W +: REG_W];
    end
  end
endmodule

// File: rtl/host_mailbox.sv
module host_mailbox
  import mbx_pkg::*;
#(
  parameter int WORDS = 4,
  localparam int BUF_W = WORDS * REG_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [MAP_AW-1:0] reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [REG_W-1:0]  req_cmd,
  output logic [REG_W-1:0]  req_src,
  output logic [REG_W-1:0]  req_dst,
  output logic [BUF_W-1:0]  req_data,
  input  logic              done_valid,
  input  logic              done_err,
  input  logic [CODE_W-1:0] done_code,
  input  logic [BUF_W-1:0]  done_data,
  output logic              irq
);
  logic [REG_W-1:0]  cmd_q;
  logic              busy;
  logic              err;
  logic [CODE_W-1:0] code;
  logic              pend;
  logic [BUF_W-1:0]  wbuf;
  logic [BUF_W-1:0]  rbuf;

  mbx_hostregs #(.WORDS(WORDS)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (reg_wr && !busy),
    .addr    (reg_addr),
    .wdata   (reg_wdata),
    .src_ptr (req_src),
    .dst_ptr (req_dst),
    .wbuf    (wbuf)
  );

  mbx_core #(.WORDS(WORDS)) u_core (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_wr     (reg_wr && reg_addr == OFF_CMD),
    .sts_wr     (reg_wr && reg_addr == OFF_STS),
    .wdata      (reg_wdata),
    .req_ready  (req_ready),
    .done_valid (done_valid),
    .done_err   (done_err),
    .done_code  (done_code),
    .done_data  (done_data),
    .cmd_q      (cmd_q),
    .busy       (busy),
    .err        (err),
    .code       (code),
    .pend       (pend),
    .req_valid  (req_valid),
    .rbuf       (rbuf)
  );

  mbx_payload_mask #(.WORDS(WORDS)) u_mask (
    .wbuf (wbuf),
    .len  (cmd_q[CMD_LEN_LSB +: CMD_LEN_W]),
    .data (req_data)
  );

  mbx_rdmux #(.WORDS(WORDS)) u_rd (
    .addr    (reg_addr),
    .cmd_q   (cmd_q),
    .busy    (busy),
    .err     (err),
    .code    (code),
    .pend    (pend),
    .src_ptr (req_src),
    .dst_ptr (req_dst),
    .wbuf    (wbuf),
    .rbuf    (rbuf),
    .rdata   (reg_rdata)
  );

  assign req_cmd = cmd_q;
  assign irq     = pend;
endmodule

// File: rtl/mbx_checker.sv
module mbx_checker
  import mbx_pkg::*;
#(
  parameter int WORDS = 4,
  localparam int BUF_W = WORDS * REG_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr,
  input logic [MAP_AW-1:0] reg_addr,
  input logic [REG_W-1:0]  reg_wdata,
  input logic              req_valid,
  input logic              req_ready,
  input logic [REG_W-1:0]  req_cmd,
  input logic [BUF_W-1:0]  req_data,
  input logic              done_valid,
  input logic              irq,
  input logic              busy,
  input logic [REG_W-1:0]  cmd_q
);
  logic done_ok;
  assign done_ok = done_valid && busy && !req_valid;

  // R2
  cmd_sets_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == OFF_CMD && !busy) |=> (busy && req_valid));

  // R2
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_cmd) && $stable(req_data)));

  // R2
  req_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> busy);

  // R4
  busy_cmd_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && reg_wr && reg_addr == OFF_CMD) |=> $stable(cmd_q));

  // R4
  no_second_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !req_valid && reg_wr && reg_addr == OFF_CMD) |=> !req_valid);

  // R5
  done_clears_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_ok |=> !busy);

  // R6
  no_irq_unrequested_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_ok && !cmd_q[CMD_IRQ_BIT] && !irq && !(reg_wr && reg_addr == OFF_CMD)) |=> !irq);

  // R7
  ack_clears_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && reg_wr && reg_addr == OFF_STS && reg_wdata[STS_PEND] && !done_ok) |=> !irq);
endmodule

bind host_mailbox mbx_checker #(.WORDS(WORDS)) u_mbx_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .reg_wr     (reg_wr),
  .reg_addr   (reg_addr),
  .reg_wdata  (reg_wdata),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .req_cmd    (req_cmd),
  .req_data   (req_data),
  .done_valid (done_valid),
  .irq        (irq),
  .busy       (busy),
  .cmd_q      (cmd_q)
);

// File: tb/host_mailbox_bench.sv
module host_mailbox_bench;
  logic         clk = 1'b0;
  logic         rst_n;
  logic         reg_wr;
  logic [7:0]   reg_addr;
  logic [31:0]  reg_wdata;
  logic [31:0]  reg_rdata;
  logic         req_valid;
  logic         req_ready;
  logic [31:0]  req_cmd;
  logic [31:0]  req_src;
  logic [31:0]  req_dst;
  logic [127:0] req_data;
  logic         done_valid;
  logic         done_err;
  logic [7:0]   done_code;
  logic [127:0] done_data;
  logic         irq;

  always #5 clk = ~clk;

  host_mailbox u_host_mailbox (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .req_valid(req_valid),
    .req_ready(req_ready), .req_cmd(req_cmd), .req_src(req_src),
    .req_dst(req_dst), .req_data(req_data), .done_valid(done_valid),
    .done_err(done_err), .done_code(done_code), .done_data(done_data),
    .irq(irq)
  );

  int n_run = 0;
  int n_fail = 0;

  logic [127:0] m_rbuf;
  logic         m_pend;
  logic [31:0]  v;

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] sts_exp(input logic b, input logic e,
                                          input logic [7:0] c, input logic p);
    return {8'h00, c, 13'h0000, p, e, b};
  endfunction

  function automatic logic [127:0] payload_exp(input logic [127:0] w, input logic [7:0] len);
    logic [127:0] r = '0;
    for (int i = 0; i < 16; i++) if (i < int'(len)) r[8*i +: 8] = w[8*i +: 8];
    return r;
  endfunction

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic pulse_done(input logic e, input logic [7:0] c, input logic [127:0] d,
                            input logic ack);
    @(negedge clk);
    done_valid = 1'b1; done_err = e; done_code = c; done_data = d;
    if (ack) begin reg_wr = 1'b1; reg_addr = 8'h04; reg_wdata = 32'h4; end
    @(negedge clk);
    done_valid = 1'b0; reg_wr = 1'b0;
  endtask

  task automatic check_rbuf(input string req);
    logic [31:0] d;
    for (int k = 0; k < 4; k++) begin
      rd(8'h90 + 8'(4 * k), d);
      chk(req, d, m_rbuf[32*k +: 32]);
    end
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog act=hung exp=finished");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0; req_ready = 1'b0;
    done_valid = 1'b0; done_err = 1'b0; done_code = '0; done_data = '0;
    m_rbuf = '0; m_pend = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(8'h04, v); chk("R1 status", v, 32'h0);
    chk("R1 irq", irq, 1'b0);
    chk("R1 req_valid", req_valid, 1'b0);
    rd(8'h00, v); chk("R1 cmd", v, 32'h0);
    rd(8'h90, v); chk("R1 rbuf", v, 32'h0);

    // R8 map readback, unmapped and read-buffer writes
    wr(8'h08, 32'h1111_2222); rd(8'h08, v); chk("R8 src", v, 32'h1111_2222);
    wr(8'h0C, 32'h3333_4444); rd(8'h0C, v); chk("R8 dst", v, 32'h3333_4444);
    wr(8'h8C, 32'hA5A5_5A5A); rd(8'h8C, v); chk("R8 wbuf", v, 32'hA5A5_5A5A);
    wr(8'h40, 32'hFFFF_FFFF); rd(8'h40, v); chk("R8 unmapped", v, 32'h0);
    rd(8'h82, v); chk("R8 unaligned", v, 32'h0);
    wr(8'h94, 32'hDEAD_BEEF); rd(8'h94, v); chk("R8 rbuf write ignored", v, 32'h0);

    // R5 completion while idle is ignored
    pulse_done(1'b1, 8'h05, {4{32'hCAFE_F00D}}, 1'b0);
    rd(8'h04, v); chk("R5 idle done status", v, 32'h0);
    check_rbuf("R5 idle done rbuf");

    for (int it = 0; it < 40; it++) begin
      logic [7:0]   op  = 8'($urandom);
      logic [3:0]   sub = 4'($urandom);
      logic [7:0]   len = (it == 0) ? 8'd16 : (it == 1) ? 8'd0 : 8'($urandom_range(0, 20));
      logic         irqf = (it < 4) ? 1'b1 : 1'($urandom_range(0, 1));
      logic [31:0]  cmd = {8'h00, len, sub, 3'b000, irqf, op};
      logic [31:0]  src = $urandom;
      logic [31:0]  dst = $urandom;
      logic [127:0] w = {$urandom, $urandom, $urandom, $urandom};
      logic         e = 1'($urandom_range(0, 1));
      logic [7:0]   c = 8'($urandom_range(1, 7));
      logic [127:0] dd = {$urandom, $urandom, $urandom, $urandom};
      logic         ack_same = (it == 2) || ((it % 7 == 3) && m_pend);

      wr(8'h08, src); wr(8'h0C, dst);
      for (int k = 0; k < 4; k++) wr(8'h80 + 8'(4 * k), w[32*k +: 32]);
      wr(8'h00, cmd);
      #1;
      // R2, R9: busy set, error cleared, request presented
      rd(8'h04, v); chk("R2 R9 status after cmd", v, sts_exp(1'b1, 1'b0, 8'h00, m_pend));
      chk("R2 req_valid", req_valid, 1'b1);
      chk("R2 req_cmd", req_cmd, cmd);
      chk("R2 req_src", req_src, src);
      chk("R2 req_dst", req_dst, dst);
      chk("R3 payload mask", req_data, payload_exp(w, len));

      repeat ($urandom_range(0, 3)) @(negedge clk);
      chk("R2 held without ready", req_valid, 1'b1);

      if (it % 5 == 1) begin
        // R5 completion while request still pending is ignored
        pulse_done(1'b0, 8'h00, dd, 1'b0);
        rd(8'h04, v); chk("R5 done before take", v, sts_exp(1'b1, 1'b0, 8'h00, m_pend));
      end
      if (it % 3 == 0) begin
        // R4 writes while busy ignored
        wr(8'h00, cmd ^ 32'h0000_0055);
        wr(8'h08, ~src);
        wr(8'h84, ~w[63:32]);
        rd(8'h00, v); chk("R4 cmd unchanged", v, cmd);
        rd(8'h08, v); chk("R4 src unchanged", v, src);
        rd(8'h84, v); chk("R4 wbuf unchanged", v, w[63:32]);
        chk("R4 payload unchanged", req_data, payload_exp(w, len));
      end

      @(negedge clk); req_ready = 1'b1;
      @(negedge clk); req_ready = 1'b0;
      #1 chk("R2 taken", req_valid, 1'b0);
      if (it % 3 == 0) begin
        wr(8'h00, cmd ^ 32'h0000_0055);
        #1 chk("R4 no second request", req_valid, 1'b0);
      end

      pulse_done(e, c, dd, ack_same);
      m_rbuf = dd;
      m_pend = irqf ? 1'b1 : (ack_same ? 1'b0 : m_pend);
      #1;
      rd(8'h04, v); chk("R5 R6 R7 status after done", v, sts_exp(1'b0, e, e ? c : 8'h00, m_pend));
      chk("R6 irq level", irq, m_pend);
      check_rbuf("R5 rbuf");

      if (m_pend && (it < 4 || $urandom_range(0, 2) != 0)) begin
        wr(8'h04, 32'h0000_0003);
        #1 chk("R7 no-bit2 write keeps irq", irq, 1'b1);
        wr(8'h04, 32'h0000_0004);
        m_pend = 1'b0;
        #1 chk("R7 ack clears irq", irq, 1'b0);
        rd(8'h04, v); chk("R7 status after ack", v, sts_exp(1'b0, e, e ? c : 8'h00, 1'b0));
      end
    end

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule